// File: doc/BRIEF.md
# Multi-Queue Status and Interrupt Bank

This block keeps the fill-level flags and the interrupt state of 64 hardware queues and shows them on a simple 32-bit word-addressed register bus. The queue engines drive per-queue condition lines into the bank every cycle. The lower half, queues 0 to 31, gives a full four-flag status, sticky underflow and overflow flags, and a programmable interrupt source for each queue. The upper half, queues 32 to 63, gives only a nearly-empty bit and a full bit for each queue, and its interrupt source is always nearly-empty.

Each queue has an enable bit and a pending bit. A global sticky control picks one of two behaviours. In sticky mode a pending bit latches and stays set until software clears it. In level mode a pending bit follows the enabled condition. Each half drives its own interrupt line. Software reads the whole state through the bus. It can also program source selects and enables, clear latched flags, and clear pending bits. Queue storage, the access windows and the bus fabric are outside this block. The bank only reserves the window address space.

Top module: `qstat_irq_bank`

## Requirements
- R1: Lower status for queue q is read at word 256+q/8, bits (q%8)*4+3..(q%8)*4. Bit 0 is empty, bit 1 is nearly-empty, bit 2 is nearly-full and bit 3 is full. The word shows the lo_cond_i nibble of queue q as sampled one clock earlier.
- R2: A one-cycle pulse on lo_uf_evt_i[q] sets bit 2*(q%16) of word 260+q/16. A pulse on lo_of_evt_i[q] sets bit 2*(q%16)+1 of the same word.
- R3: An underflow or overflow flag stays set until a write to its word carries 0 in that bit position. Writing 1 neither sets nor clears a flag. An event in the same cycle as a clearing write leaves the flag set.
- R4: Word 262 bit q-32 shows the nearly-empty input of upper queue q, and word 263 bit q-32 shows its full input. Both are sampled one clock earlier.
- R5: Word 264+q/8, bits (q%8)*4+3..(q%8)*4, holds the source select nibble of lower queue q and reads back as written. Select bits 1..0 give the index of the status bit used, and select bit 2 inverts that bit.
- R6: Bit 3 of word 264 turns on sticky mode. In sticky mode a pending bit is set when its enabled condition is true, and it stays set after the condition goes away. Writing 1 to the bit in the pending word clears it. If the condition is still true in the same cycle, the bit stays set.
- R7: In level mode a pending bit equals its enabled condition of the previous cycle, and writes to the pending words have no effect.
- R8: The condition of an upper queue is its nearly-empty input alone. Its full input never raises pending.
- R9: Words 268 (queues 0-31) and 269 (queues 32-63) hold one enable bit per queue. A pending bit never becomes set while its enable bit is clear.
- R10: irq_lo_o is high exactly when some lower queue has both pending and enable set. irq_hi_o follows the same rule for the upper queues. The pending words are 270 (lower) and 271 (upper).
- R11: Access-window words 0-255 and words from 272 up read as zero. Writes to them, and writes to the status words 256-259, 262 and 263, are ignored.
- R12: After reset every register reads zero and both interrupt lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | ADDR_W | Word address |
| bus_we_i | input | 1 | Write strobe, acts on the rising edge |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational from state |
| lo_cond_i | input | NUM_LO*4 | Four status flags per lower queue, nibble per queue |
| lo_uf_evt_i | input | NUM_LO | Underflow event pulse per lower queue |
| lo_of_evt_i | input | NUM_LO | Overflow event pulse per lower queue |
| hi_ne_i | input | NUM_HI | Nearly-empty per upper queue |
| hi_full_i | input | NUM_HI | Full per upper queue |
| irq_lo_o | output | 1 | Interrupt for queues 0-31 |
| irq_hi_o | output | 1 | Interrupt for queues 32-63 |

## Verification
The bench drives every lower queue through every one of the eight source selects and checks the pending word. A design with the inversion bit or the index bits swapped would latch the wrong queues. Every lower queue also goes through an underflow and overflow set, then a clear of one bit with the other kept, then a write of all ones. A design that used write-1-to-clear there, or that let an event be lost to a clearing write in the same cycle, would show the wrong flags. In sticky mode the bench removes the condition, drops the enable, and clears while the condition is still present. A bank that let pending follow the level, gated pending by the enable, or let the clear win would fail. The upper half is driven with full alone to catch a design that raises pending from the wrong source.

// File: rtl/qsb_pkg.sv
package qsb_pkg;

    localparam int WORD_W        = 32;
    localparam int ST_W          = 4;   // status flags per lower queue
    localparam int ACC_WORDS_PER_Q = 4; // reserved access window per queue
    localparam int UO_W          = 2;   // underflow/overflow bits per lower queue

    // status nibble bit positions
    localparam int ST_EMPTY = 0;
    localparam int ST_NE    = 1;
    localparam int ST_NF    = 2;
    localparam int ST_FULL  = 3;

    // source select nibble fields
    localparam int SEL_INV_BIT    = 2;
    localparam int SEL_STICKY_BIT = 3; // meaningful in queue 0's nibble only

    typedef enum logic [3:0] {
        RG_NONE,
        RG_ACC,
        RG_LSTAT,
        RG_UO,
        RG_HNE,
        RG_HFULL,
        RG_SEL,
        RG_IEN,
        RG_PEND
    } region_e;

    // selected interrupt condition of one lower queue
    function automatic logic src_match(input logic [ST_W-1:0] st,
                                       input logic [ST_W-1:0] sel);
        return sel[SEL_INV_BIT] ^ st[sel[1:0]];
    endfunction

endpackage

// File: rtl/qsb_decode.sv
module qsb_decode
    import qsb_pkg::*;
#(
    parameter int NUM_LO = 32,
    parameter int NUM_HI = 32,
    parameter int ADDR_W = 9
) (
    input  logic [ADDR_W-1:0] addr_i,
    output region_e           region_o,
    output logic [ADDR_W-1:0] idx_o
);

    localparam int ACC_N   = (NUM_LO + NUM_HI) * ACC_WORDS_PER_Q;
    localparam int LSTAT_B = ACC_N;
    localparam int LSTAT_N = NUM_LO / (WORD_W / ST_W);
    localparam int UO_B    = LSTAT_B + LSTAT_N;
    localparam int UO_N    = NUM_LO / (WORD_W / UO_W);
    localparam int HNE_B   = UO_B + UO_N;
    localparam int HI_N    = NUM_HI / WORD_W;
    localparam int HF_B    = HNE_B + HI_N;
    localparam int SEL_B   = HF_B + HI_N;
    localparam int SEL_N   = NUM_LO / (WORD_W / ST_W);
    localparam int IEN_B   = SEL_B + SEL_N;
    localparam int BIT_N   = (NUM_LO + NUM_HI) / WORD_W;
    localparam int PEND_B  = IEN_B + BIT_N;
    localparam int END_B   = PEND_B + BIT_N;

    logic [31:0] a_w;
    assign a_w = 32'(addr_i);

    always_comb begin
        region_o = RG_NONE;
        idx_o    = '0;
        if (a_w < 32'(ACC_N)) begin
            region_o = RG_ACC;
        end else if (a_w < 32'(UO_B)) begin
            region_o = RG_LSTAT;
            idx_o    = ADDR_W'(a_w - 32'(LSTAT_B));
        end else if (a_w < 32'(HNE_B)) begin
            region_o = RG_UO;
            idx_o    = ADDR_W'(a_w - 32'(UO_B));
        end else if (a_w < 32'(HF_B)) begin
            region_o = RG_HNE;
            idx_o    = ADDR_W'(a_w - 32'(HNE_B));
        end else if (a_w < 32'(SEL_B)) begin
            region_o = RG_HFULL;
            idx_o    = ADDR_W'(a_w - 32'(HF_B));
        end else if (a_w < 32'(IEN_B)) begin
            region_o = RG_SEL;
            idx_o    = ADDR_W'(a_w - 32'(SEL_B));
        end else if (a_w < 32'(PEND_B)) begin
            region_o = RG_IEN;
            idx_o    = ADDR_W'(a_w - 32'(IEN_B));
        end else if (a_w < 32'(END_B)) begin
            region_o = RG_PEND;
            idx_o    = ADDR_W'(a_w - 32'(PEND_B));
        end
    end

endmodule

// File: rtl/qsb_lo_bank.sv
module qsb_lo_bank
    import qsb_pkg::*;
#(
    parameter int NUM_LO = 32,
    parameter int IDX_W  = 9
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic [NUM_LO*ST_W-1:0] cond_i,
    input  logic [NUM_LO-1:0]      uf_evt_i,
    input  logic [NUM_LO-1:0]      of_evt_i,
    input  logic                   wr_uo_i,
    input  logic                   wr_sel_i,
    input  logic                   wr_ien_i,
    input  logic                   wr_pend_i,
    input  logic [IDX_W-1:0]       idx_i,
    input  logic [WORD_W-1:0]      wdata_i,
    output logic [NUM_LO*ST_W-1:0] stat_o,
    output logic [NUM_LO*UO_W-1:0] uo_o,
    output logic [NUM_LO*ST_W-1:0] sel_o,
    output logic [NUM_LO-1:0]      ien_o,
    output logic [NUM_LO-1:0]      pend_o,
    output logic                   sticky_o,
    output logic                   irq_o
);

    localparam int UO_PER_W  = WORD_W / UO_W;
    localparam int SEL_PER_W = WORD_W / ST_W;

    typedef struct packed {
        logic [NUM_LO*ST_W-1:0] stat;
        logic [NUM_LO*UO_W-1:0] uo;
        logic [NUM_LO*ST_W-1:0] sel;
        logic [NUM_LO-1:0]      ien;
        logic [NUM_LO-1:0]      pend;
    } lo_state_t;

    lo_state_t    st_q, st_d;
    logic [NUM_LO-1:0] hit, clr;
    logic         sticky;

    assign sticky = st_q.sel[SEL_STICKY_BIT];

    always_comb begin
        st_d      = st_q;
        st_d.stat = cond_i;
        hit       = '0;
        clr       = '0;
        for (int q = 0; q < NUM_LO; q++) begin
            // clear by writing 0; new events always win
            st_d.uo[UO_W*q +: UO_W] =
                (st_q.uo[UO_W*q +: UO_W] &
                 ((wr_uo_i && idx_i == IDX_W'(q / UO_PER_W))
                    ? wdata_i[(q % UO_PER_W)*UO_W +: UO_W] : 2'b11))
                | {of_evt_i[q], uf_evt_i[q]};

            if (wr_sel_i && idx_i == IDX_W'(q / SEL_PER_W))
                st_d.sel[ST_W*q +: ST_W] = wdata_i[(q % SEL_PER_W)*ST_W +: ST_W];

            if (wr_ien_i && idx_i == IDX_W'(q / WORD_W))
                st_d.ien[q] = wdata_i[q % WORD_W];

            hit[q] = src_match(st_q.stat[ST_W*q +: ST_W], st_q.sel[ST_W*q +: ST_W])
                     & st_q.ien[q];
            clr[q] = wr_pend_i && idx_i == IDX_W'(q / WORD_W) && wdata_i[q % WORD_W];

            st_d.pend[q] = sticky ? ((st_q.pend[q] & ~clr[q]) | hit[q]) : hit[q];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign stat_o   = st_q.stat;
    assign uo_o     = st_q.uo;
    assign sel_o    = st_q.sel;
    assign ien_o    = st_q.ien;
    assign pend_o   = st_q.pend;
    assign sticky_o = sticky;
    assign irq_o    = |(st_q.pend & st_q.ien);

endmodule

// File: rtl/qsb_hi_bank.sv
module qsb_hi_bank
    import qsb_pkg::*;
#(
    parameter int NUM_HI = 32,
    parameter int IDX_W  = 9
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [NUM_HI-1:0] ne_i,
    input  logic [NUM_HI-1:0] full_i,
    input  logic              sticky_i,
    input  logic              wr_ien_i,
    input  logic              wr_pend_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic [NUM_HI-1:0] ne_o,
    output logic [NUM_HI-1:0] full_o,
    output logic [NUM_HI-1:0] ien_o,
    output logic [NUM_HI-1:0] pend_o,
    output logic              irq_o
);

    typedef struct packed {
        logic [NUM_HI-1:0] ne;
        logic [NUM_HI-1:0] full;
        logic [NUM_HI-1:0] ien;
        logic [NUM_HI-1:0] pend;
    } hi_state_t;

    hi_state_t         st_q, st_d;
    logic [NUM_HI-1:0] hit, clr;

    always_comb begin
        st_d      = st_q;
        st_d.ne   = ne_i;
        st_d.full = full_i;
        hit       = '0;
        clr       = '0;
        for (int q = 0; q < NUM_HI; q++) begin
            if (wr_ien_i && idx_i == IDX_W'(q / WORD_W))
                st_d.ien[q] = wdata_i[q % WORD_W];
            // source fixed to nearly-empty
            hit[q] = st_q.ne[q] & st_q.ien[q];
            clr[q] = wr_pend_i && idx_i == IDX_W'(q / WORD_W) && wdata_i[q % WORD_W];
            st_d.pend[q] = sticky_i ? ((st_q.pend[q] & ~clr[q]) | hit[q]) : hit[q];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign ne_o   = st_q.ne;
    assign full_o = st_q.full;
    assign ien_o  = st_q.ien;
    assign pend_o = st_q.pend;
    assign irq_o  = |(st_q.pend & st_q.ien);

endmodule

// File: rtl/qstat_irq_bank.sv
module qstat_irq_bank
    import qsb_pkg::*;
#(
    parameter int NUM_LO = 32,
    parameter int NUM_HI = 32,
    parameter int ADDR_W = 9
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic [ADDR_W-1:0]      bus_addr_i,
    input  logic                   bus_we_i,
    input  logic [WORD_W-1:0]      bus_wdata_i,
    output logic [WORD_W-1:0]      bus_rdata_o,
    input  logic [NUM_LO*ST_W-1:0] lo_cond_i,
    input  logic [NUM_LO-1:0]      lo_uf_evt_i,
    input  logic [NUM_LO-1:0]      lo_of_evt_i,
    input  logic [NUM_HI-1:0]      hi_ne_i,
    input  logic [NUM_HI-1:0]      hi_full_i,
    output logic                   irq_lo_o,
    output logic                   irq_hi_o
);

    localparam int LO_BW = NUM_LO / WORD_W;
    localparam int NUM_Q = NUM_LO + NUM_HI;

    region_e           region;
    logic [ADDR_W-1:0] idx, hi_idx;
    logic              in_lo_bits;
    logic              wr_uo, wr_sel, wr_ien_lo, wr_pend_lo, wr_ien_hi, wr_pend_hi;

    logic [NUM_LO*ST_W-1:0] lo_stat, lo_sel;
    logic [NUM_LO*UO_W-1:0] lo_uo;
    logic [NUM_LO-1:0]      lo_ien, lo_pend;
    logic [NUM_HI-1:0]      hi_ne, hi_full, hi_ien, hi_pend;
    logic [NUM_Q-1:0]       all_ien, all_pend;
    logic                   sticky;

    qsb_decode #(
        .NUM_LO (NUM_LO),
        .NUM_HI (NUM_HI),
        .ADDR_W (ADDR_W)
    ) i_decode (
        .addr_i   (bus_addr_i),
        .region_o (region),
        .idx_o    (idx)
    );

    assign in_lo_bits = idx < ADDR_W'(LO_BW);
    assign hi_idx     = idx - ADDR_W'(LO_BW);
    assign wr_uo      = bus_we_i && region == RG_UO;
    assign wr_sel     = bus_we_i && region == RG_SEL;
    assign wr_ien_lo  = bus_we_i && region == RG_IEN  &&  in_lo_bits;
    assign wr_pend_lo = bus_we_i && region == RG_PEND &&  in_lo_bits;
    assign wr_ien_hi  = bus_we_i && region == RG_IEN  && !in_lo_bits;
    assign wr_pend_hi = bus_we_i && region == RG_PEND && !in_lo_bits;

    qsb_lo_bank #(
        .NUM_LO (NUM_LO),
        .IDX_W  (ADDR_W)
    ) i_lo_bank (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .cond_i    (lo_cond_i),
        .uf_evt_i  (lo_uf_evt_i),
        .of_evt_i  (lo_of_evt_i),
        .wr_uo_i   (wr_uo),
        .wr_sel_i  (wr_sel),
        .wr_ien_i  (wr_ien_lo),
        .wr_pend_i (wr_pend_lo),
        .idx_i     (idx),
        .wdata_i   (bus_wdata_i),
        .stat_o    (lo_stat),
        .uo_o      (lo_uo),
        .sel_o     (lo_sel),
        .ien_o     (lo_ien),
        .pend_o    (lo_pend),
        .sticky_o  (sticky),
        .irq_o     (irq_lo_o)
    );

    qsb_hi_bank #(
        .NUM_HI (NUM_HI),
        .IDX_W  (ADDR_W)
    ) i_hi_bank (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .ne_i      (hi_ne_i),
        .full_i    (hi_full_i),
        .sticky_i  (sticky),
        .wr_ien_i  (wr_ien_hi),
        .wr_pend_i (wr_pend_hi),
        .idx_i     (hi_idx),
        .wdata_i   (bus_wdata_i),
        .ne_o      (hi_ne),
        .full_o    (hi_full),
        .ien_o     (hi_ien),
        .pend_o    (hi_pend),
        .irq_o     (irq_hi_o)
    );

    assign all_ien  = {hi_ien, lo_ien};
    assign all_pend = {hi_pend, lo_pend};

    always_comb begin
        bus_rdata_o = '0;
        case (region)
            RG_LSTAT: bus_rdata_o = lo_stat[int'(idx)*WORD_W +: WORD_W];
            RG_UO:    bus_rdata_o = lo_uo[int'(idx)*WORD_W +: WORD_W];
            RG_HNE:   bus_rdata_o = hi_ne[int'(idx)*WORD_W +: WORD_W];
            RG_HFULL: bus_rdata_o = hi_full[int'(idx)*WORD_W +: WORD_W];
            RG_SEL:   bus_rdata_o = lo_sel[int'(idx)*WORD_W +: WORD_W];
            RG_IEN:   bus_rdata_o = all_ien[int'(idx)*WORD_W +: WORD_W];
            RG_PEND:  bus_rdata_o = all_pend[int'(idx)*WORD_W +: WORD_W];
            default:  bus_rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/qsb_checker.sv
module qsb_checker #(
    parameter int NUM_LO = 32,
    parameter int NUM_HI = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_LO*4-1:0]  lo_cond,
    input logic [NUM_LO-1:0]    lo_uf_evt,
    input logic [NUM_LO*4-1:0]  lo_stat,
    input logic [NUM_LO*2-1:0]  lo_uo,
    input logic [NUM_LO-1:0]    lo_ien,
    input logic [NUM_LO-1:0]    lo_pend,
    input logic [NUM_HI-1:0]    hi_ne,
    input logic [NUM_HI-1:0]    hi_ien,
    input logic [NUM_HI-1:0]    hi_pend,
    input logic                 sticky,
    input logic                 wr_uo,
    input logic                 wr_pend_hi,
    input logic                 irq_lo,
    input logic                 irq_hi
);

    logic [NUM_LO-1:0] uf_view;
    always_comb begin
        for (int q = 0; q < NUM_LO; q++) uf_view[q] = lo_uo[2*q];
    end

    assert_stat_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> lo_stat == $past(lo_cond));

    assert_uf_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (uf_view & $past(lo_uf_evt)) == $past(lo_uf_evt));

    assert_uo_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_uo |=> (lo_uo & $past(lo_uo)) == $past(lo_uo));

    assert_sticky_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sticky && !wr_pend_hi) |=> (hi_pend & $past(hi_pend)) == $past(hi_pend));

    assert_hi_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !sticky |=> hi_pend == $past(hi_ne & hi_ien));

    assert_new_pend_enabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((lo_pend & ~$past(lo_pend) & ~$past(lo_ien)) == '0) &&
                 ((hi_pend & ~$past(hi_pend) & ~$past(hi_ien)) == '0));

    assert_irq_lo_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_ien == '0) |-> !irq_lo);

    assert_irq_hi_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_pend == '0) |-> !irq_hi);

endmodule

bind qstat_irq_bank qsb_checker #(
    .NUM_LO (NUM_LO),
    .NUM_HI (NUM_HI)
) i_qsb_checker (
    .clk        (clk_i),
    .rst_n      (rst_ni),
    .lo_cond    (lo_cond_i),
    .lo_uf_evt  (lo_uf_evt_i),
    .lo_stat    (lo_stat),
    .lo_uo      (lo_uo),
    .lo_ien     (lo_ien),
    .lo_pend    (lo_pend),
    .hi_ne      (hi_ne),
    .hi_ien     (hi_ien),
    .hi_pend    (hi_pend),
    .sticky     (sticky),
    .wr_uo      (wr_uo),
    .wr_pend_hi (wr_pend_hi),
    .irq_lo     (irq_lo_o),
    .irq_hi     (irq_hi_o)
);

// File: tb/test_qstat_irq_bank.sv
module test_qstat_irq_bank;

    localparam int NL = 32, NH = 32, AW = 9;
    localparam int A_LST = 256, A_UO = 260, A_HNE = 262, A_HF = 263;
    localparam int A_SEL = 264, A_IEN = 268, A_PEND = 270;

    logic           clk = 1'b0;
    logic           rst_n;
    logic [AW-1:0]  addr;
    logic           we;
    logic [31:0]    wdata, rdata;
    logic [NL*4-1:0] lo_cond;
    logic [NL-1:0]  uf_evt, of_evt;
    logic [NH-1:0]  hne, hfull;
    logic           irq_lo, irq_hi;
    logic [3:0]     lc [NL];

    int n_chk = 0, n_bad = 0;

    always #5 clk = ~clk;

    always_comb begin
        for (int i = 0; i < NL; i++) lo_cond[4*i +: 4] = lc[i];
    end

    qstat_irq_bank #(.NUM_LO(NL), .NUM_HI(NH), .ADDR_W(AW)) i_qstat_irq_bank (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .bus_addr_i  (addr),
        .bus_we_i    (we),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .lo_cond_i   (lo_cond),
        .lo_uf_evt_i (uf_evt),
        .lo_of_evt_i (of_evt),
        .hi_ne_i     (hne),
        .hi_full_i   (hfull),
        .irq_lo_o    (irq_lo),
        .irq_hi_o    (irq_hi)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        addr = AW'(a);
        we   = 1'b0;
        #1 d = rdata;
    endtask

    task automatic rdchk(input string req, input int a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(req, d, exp);
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        addr  = AW'(a);
        wdata = d;
        we    = 1'b1;
        @(negedge clk);
        we    = 1'b0;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    function automatic logic [31:0] lstat_word(input int w);
        logic [31:0] r = '0;
        for (int i = 0; i < 8; i++) r[4*i +: 4] = lc[8*w + i];
        return r;
    endfunction

    // expected level condition for select s on all lower queues
    function automatic logic [31:0] lvl(input int s);
        logic [31:0] r = '0;
        for (int q = 0; q < NL; q++) r[q] = lc[q][s & 3] ^ s[2];
        return r;
    endfunction

    task automatic sel_all(input logic [3:0] nib, input logic stky);
        logic [31:0] w = {8{nib}};
        for (int i = 1; i < 4; i++) wr(A_SEL + i, w);
        wr(A_SEL, {w[31:4], stky, w[2:0]});
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] d, e;
        rst_n = 1'b0; addr = '0; we = 1'b0; wdata = '0;
        uf_evt = '0; of_evt = '0; hne = '0; hfull = '0;
        for (int i = 0; i < NL; i++) lc[i] = 4'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R12: reset state
        for (int a = A_LST; a < 272; a++) rdchk("R12 reset word", a, 32'h0);
        chk("R12 irq_lo", {31'b0, irq_lo}, 32'h0);
        chk("R12 irq_hi", {31'b0, irq_hi}, 32'h0);

        // R1: lower status packing over 16 patterns
        for (int k = 0; k < 16; k++) begin
            for (int q = 0; q < NL; q++) lc[q] = 4'((q*5 + k) & 15);
            settle();
            for (int w = 0; w < 4; w++) rdchk("R1 lower status", A_LST + w, lstat_word(w));
        end
        // R11: status words ignore writes
        wr(A_LST + 1, 32'hDEAD_BEEF);
        rdchk("R11 status write ignored", A_LST + 1, lstat_word(1));

        // R4: upper status
        for (int k = 0; k < 8; k++) begin
            hne   = 32'h9E37_79B9 * (k + 1);
            hfull = ~hne ^ 32'(k << 3);
            settle();
            rdchk("R4 upper ne", A_HNE, hne);
            rdchk("R4 upper full", A_HF, hfull);
        end
        wr(A_HNE, 32'hFFFF_FFFF);
        wr(A_HF, 32'h0);
        rdchk("R11 upper ne write ignored", A_HNE, hne);
        rdchk("R11 upper full write ignored", A_HF, hfull);
        hne = '0; hfull = '0;

        // R11: windows and unmapped
        wr(17, 32'hFFFF_FFFF);
        wr(300, 32'hFFFF_FFFF);
        rdchk("R11 window 0", 0, 32'h0);
        rdchk("R11 window 17", 17, 32'h0);
        rdchk("R11 window 255", 255, 32'h0);
        rdchk("R11 unmapped 272", 272, 32'h0);
        rdchk("R11 unmapped 511", 511, 32'h0);

        // R2 / R3: underflow and overflow per queue
        for (int q = 0; q < NL; q++) begin
            logic [31:0] ub, ob;
            ub = 32'h1 << (2*(q % 16));
            ob = 32'h1 << (2*(q % 16) + 1);
            @(negedge clk); uf_evt[q] = 1'b1;
            @(negedge clk); uf_evt[q] = 1'b0;
            rdchk("R2 underflow set", A_UO + q/16, ub);
            @(negedge clk); of_evt[q] = 1'b1;
            @(negedge clk); of_evt[q] = 1'b0;
            rdchk("R2 overflow set", A_UO + q/16, ub | ob);
            wr(A_UO + q/16, ob);
            rdchk("R3 clear underflow only", A_UO + q/16, ob);
            wr(A_UO + q/16, 32'hFFFF_FFFF);
            rdchk("R3 write ones keeps", A_UO + q/16, ob);
            wr(A_UO + q/16, 32'h0);
            rdchk("R3 clear all", A_UO + q/16, 32'h0);
        end
        // R3: event beats a clearing write in the same cycle
        @(negedge clk);
        uf_evt[3] = 1'b1; addr = AW'(A_UO); wdata = 32'h0; we = 1'b1;
        @(negedge clk);
        uf_evt[3] = 1'b0; we = 1'b0;
        rdchk("R3 event wins over clear", A_UO, 32'h1 << 6);
        wr(A_UO, 32'h0);
        rdchk("R3 cleared after race", A_UO, 32'h0);

        // R5: select readback
        for (int w = 0; w < 4; w++) begin
            e = 32'h7654_3210 ^ (32'h1111_1111 * w);
            if (w == 0) e[3] = 1'b0;
            wr(A_SEL + w, e);
            rdchk("R5 select readback", A_SEL + w, e);
        end

        // R7 / R10: level mode, all selects
        wr(A_IEN, 32'hFFFF_FFFF);
        for (int s = 0; s < 8; s++) begin
            sel_all(4'(s), 1'b0);
            for (int k = 0; k < 2; k++) begin
                for (int q = 0; q < NL; q++) lc[q] = 4'((q*3 + k*7 + s) & 15);
                settle();
                e = lvl(s);
                rdchk("R7 level pending", A_PEND, e);
                chk("R10 irq_lo level", {31'b0, irq_lo}, {31'b0, e != 0});
            end
        end
        wr(A_PEND, 32'hFFFF_FFFF);
        rdchk("R7 write ignored in level mode", A_PEND, lvl(7));

        // R9: partial enables
        wr(A_IEN, 32'h0000_FFFF);
        settle();
        rdchk("R9 pending masked by enable", A_PEND, lvl(7) & 32'h0000_FFFF);
        wr(A_IEN, 32'h0);
        settle();
        rdchk("R9 no pending when disabled", A_PEND, 32'h0);
        chk("R10 irq_lo off", {31'b0, irq_lo}, 32'h0);

        // R6: sticky mode, source nearly-empty
        for (int q = 0; q < NL; q++) lc[q] = 4'h0;
        sel_all(4'h1, 1'b0);
        wr(A_IEN, 32'hFFFF_FFFF);
        settle();
        rdchk("R7 quiet before sticky", A_PEND, 32'h0);
        sel_all(4'h1, 1'b1);
        lc[5] = 4'b0010;
        settle();
        rdchk("R6 sticky set", A_PEND, 32'h1 << 5);
        lc[5] = 4'h0;
        settle();
        rdchk("R6 sticky holds", A_PEND, 32'h1 << 5);
        chk("R10 irq_lo sticky", {31'b0, irq_lo}, 32'h1);
        wr(A_IEN, 32'h0);
        chk("R10 irq_lo gated by enable", {31'b0, irq_lo}, 32'h0);
        rdchk("R6 pending kept with enable off", A_PEND, 32'h1 << 5);
        wr(A_IEN, 32'hFFFF_FFFF);
        wr(A_PEND, 32'h1 << 5);
        rdchk("R6 write one clears", A_PEND, 32'h0);
        lc[9] = 4'b0010;
        settle();
        wr(A_PEND, 32'h1 << 9);
        rdchk("R6 condition beats clear", A_PEND, 32'h1 << 9);
        lc[9] = 4'h0;
        settle();
        wr(A_PEND, 32'h1 << 9);
        rdchk("R6 clear after condition gone", A_PEND, 32'h0);

        // R8: upper half, still sticky
        wr(A_IEN + 1, 32'hFFFF_FFFF);
        hne = 32'h0000_00F0; hfull = 32'hFFFF_0000;
        settle();
        rdchk("R8 upper pending from ne", A_PEND + 1, 32'h0000_00F0);
        chk("R10 irq_hi on", {31'b0, irq_hi}, 32'h1);
        hne = '0;
        settle();
        rdchk("R6 upper sticky holds", A_PEND + 1, 32'h0000_00F0);
        wr(A_PEND + 1, 32'h0000_00F0);
        rdchk("R6 upper clear", A_PEND + 1, 32'h0);
        chk("R10 irq_hi off", {31'b0, irq_hi}, 32'h0);
        sel_all(4'h1, 1'b0);
        hne = 32'h0000_0F0F;
        settle();
        rdchk("R8 upper level", A_PEND + 1, 32'h0000_0F0F);
        hne = '0; hfull = 32'hFFFF_FFFF;
        settle();
        rdchk("R8 full alone never pends", A_PEND + 1, 32'h0);
        chk("R10 irq_hi quiet", {31'b0, irq_hi}, 32'h0);

        d = '0;
        finish_run();
    end

endmodule